// File: doc/BRIEF.md
# Read-Launched Clock Activity Meter

This block estimates how busy four external clock lines are by counting their rising edges over a fixed stretch of the internal clock. A one-cycle start strobe, produced elsewhere whenever the host reads the result register, clears all four counters and opens a counting window. The window lasts exactly 200 internal cycles. When it closes, the four counts stay frozen until the next strobe. A host therefore reads once to launch a measurement and reads again later to collect it.

Each external line is asynchronous to the internal clock. It passes through a two-stage synchronizer, and one more flop turns it into a one-cycle rising-edge pulse. Counters do not wrap. A busy flag marks the open window. The block also passes the raw levels of the four clock lines and four companion pretrigger lines through to a separate 8-bit status word.

Top module: `clkWindowMeter`

## Requirements
- R1: While reset is asserted and right after it, `busy` is 0 and `countWord` is all zeros.
- R2: `busy` goes high in the first cycle after a cycle with `startPulse` high. It stays high for exactly WINDOW_LEN (default 200) consecutive cycles, then drops.
- R3: The clock edge that samples `startPulse` high clears every counter, so a new window's result never includes counts from the previous window.
- R4: While the window is open, each counter adds one for every rising edge seen on its synchronized external line. The counter of a line that stays low does not change.
- R5: Counter i sits at `countWord[8*i+7 : 8*i]`: channel 0 in bits 7..0 and channel 3 in bits 31..24.
- R6: When no window is open, edges on the external lines are ignored and `countWord` holds its value.
- R7: A `startPulse` during an open window clears the counters and restarts a full WINDOW_LEN window from that point. `busy` stays high throughout the restart.
- R8: A counter that reaches its all-ones value (255 for the default width) stays there instead of wrapping to zero.
- R9: `levelWord` equals `{extPre, extClk}`: pretrigger levels in bits 7..4 and clock levels in bits 3..0. It follows the inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | One-cycle strobe from a result-register read |
| extClk | input | 4 | Asynchronous external clock lines |
| extPre | input | 4 | Raw pretrigger lines, passed to the level word |
| busy | output | 1 | Window open |
| countWord | output | 32 | Four packed edge counts |
| levelWord | output | 8 | Raw levels of the pretrigger and clock lines |

## Verification
The hardest case to reach is a restart inside an open window. A second strobe must arrive after edges have been counted but before the window ends. The bench launches a window, sends a short burst of edges, leaves a gap so no edge is still in the synchronizer, and strobes again. It then expects only the second burst in the result and a busy period that stretches by the elapsed time. Saturation cannot be reached at the default width within a 200-cycle window. A second instance with 4-bit counters is driven in parallel, so its fast channels pin at 15 while its slow channel still counts exactly.

// File: rtl/clkWindowMeterPkg.sv
package clkWindowMeterPkg;

  // Strobes passed from window control to the counting datapath
  typedef struct packed {
    logic clearCnt;  // zero all counters this edge
    logic countEn;   // window open, edges may be counted
  } meterStrobes_t;

endpackage

// File: rtl/meterWindowCtrl.sv
module meterWindowCtrl
  import clkWindowMeterPkg::*;
#(
  parameter int WINDOW_LEN = 200
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  output logic          busy,
  output meterStrobes_t strobes
);

  localparam int CW = (WINDOW_LEN > 1) ? $clog2(WINDOW_LEN) : 1;
  localparam logic [CW-1:0] LAST_TICK = CW'(WINDOW_LEN - 1);

  logic [CW-1:0] windowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      windowCnt <= '0;
    end else if (startPulse) begin
      busy      <= 1'b1;
      windowCnt <= '0;
    end else if (busy) begin
      if (windowCnt == LAST_TICK) begin
        busy <= 1'b0;
      end else begin
        windowCnt <= windowCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.clearCnt = startPulse;
    strobes.countEn  = busy;
  end

endmodule

// File: rtl/meterCountPath.sv
module meterCountPath
  import clkWindowMeterPkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  meterStrobes_t           strobes,
  input  logic [NUM_CH-1:0]       extClk,
  output logic [NUM_CH*CNT_W-1:0] countWord
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevLvl;
    logic                   riseSeen;
    logic [CNT_W-1:0]       edgeCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ   <= '0;
        prevLvl <= 1'b0;
      end else begin
        syncQ   <= {syncQ[SYNC_STAGES-2:0], extClk[ch]};
        prevLvl <= syncQ[SYNC_STAGES-1];
      end
    end

    assign riseSeen = syncQ[SYNC_STAGES-1] & ~prevLvl;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        edgeCnt <= '0;
      end else if (strobes.clearCnt) begin
        edgeCnt <= '0;
      end else if (strobes.countEn && riseSeen && (edgeCnt != CNT_MAX)) begin
        edgeCnt <= edgeCnt + 1'b1;
      end
    end

    assign countWord[ch*CNT_W +: CNT_W] = edgeCnt;
  end

endmodule

// File: rtl/clkWindowMeter.sv
module clkWindowMeter
  import clkWindowMeterPkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int CNT_W       = 8,
  parameter int WINDOW_LEN  = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startPulse,
  input  logic [NUM_CH-1:0]       extClk,
  input  logic [NUM_CH-1:0]       extPre,
  output logic                    busy,
  output logic [NUM_CH*CNT_W-1:0] countWord,
  output logic [2*NUM_CH-1:0]     levelWord
);

  meterStrobes_t strobes;

  meterWindowCtrl #(.WINDOW_LEN(WINDOW_LEN)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .busy      (busy),
    .strobes   (strobes)
  );

  meterCountPath #(
    .NUM_CH     (NUM_CH),
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .extClk   (extClk),
    .countWord(countWord)
  );

  assign levelWord = {extPre, extClk};

endmodule

// File: rtl/clkWindowMeterChk.sv
module clkWindowMeterChk #(
  parameter int NUM_CH     = 4,
  parameter int CNT_W      = 8,
  parameter int WINDOW_LEN = 200
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    startPulse,
  input logic                    busy,
  input logic [NUM_CH*CNT_W-1:0] countWord
);

  localparam int RW = $clog2(WINDOW_LEN + 1);

  logic [RW-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (startPulse) runLen <= '0;
    else if (busy) runLen <= runLen + 1'b1;
  end

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> busy); // R2

  AST_RISE_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startPulse)); // R2

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runLen < RW'(WINDOW_LEN))); // R2

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (countWord == '0)); // R3

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startPulse) |=> $stable(countWord)); // R6

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gFld
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
      !startPulse |=> (countWord[ch*CNT_W +: CNT_W] >= $past(countWord[ch*CNT_W +: CNT_W]))); // R8

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
      !startPulse |=> ({1'b0, countWord[ch*CNT_W +: CNT_W]} <= {1'b0, $past(countWord[ch*CNT_W +: CNT_W])} + 1'b1)); // R4
  end

endmodule

bind clkWindowMeter clkWindowMeterChk #(
  .NUM_CH    (NUM_CH),
  .CNT_W     (CNT_W),
  .WINDOW_LEN(WINDOW_LEN)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .startPulse(startPulse),
  .busy      (busy),
  .countWord (countWord)
);

// File: tb/clkWindowMeter_test.sv
module clkWindowMeter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [3:0]  extClk = '0;
  logic [3:0]  extPre = '0;
  logic        busy;
  logic [31:0] countWord;
  logic [7:0]  levelWord;
  logic        busyN;
  logic [15:0] countN;
  logic [7:0]  levelN;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  typedef struct {
    logic [31:0] word;
    int          len;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  clkWindowMeter uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .extClk(extClk),
    .extPre(extPre), .busy(busy), .countWord(countWord), .levelWord(levelWord)
  );

  // narrow-counter copy so saturation is reachable (R8)
  clkWindowMeter #(.CNT_W(4)) uutNarrow (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .extClk(extClk),
    .extPre(extPre), .busy(busyN), .countWord(countN), .levelWord(levelN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive a one-cycle start; returns at the negedge after it with start low
  task automatic fire(output int atCyc);
    @(negedge clk);
    atCyc = cyc;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic pulses(input int a, input int b, input int c, input int d);
    int mx;
    mx = a;
    if (b > mx) mx = b;
    if (c > mx) mx = c;
    if (d > mx) mx = d;
    for (int k = 0; k < 2 * mx; k++) begin
      @(negedge clk);
      extClk[0] = (k < 2 * a) && (k % 2 == 0);
      extClk[1] = (k < 2 * b) && (k % 2 == 0);
      extClk[2] = (k < 2 * c) && (k % 2 == 0);
      extClk[3] = (k < 2 * d) && (k % 2 == 0);
    end
    @(negedge clk);
    extClk = '0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: on each window close, compare result and busy length
  initial begin
    int runLen;
    logic prevBusy;
    expItem_t it;
    runLen = 0;
    prevBusy = 1'b0;
    forever begin
      @(negedge clk);
      if (busy) runLen++;
      if (prevBusy && !busy) begin
        total++;
        if (expQ.size() == 0) begin
          bad++;
          $display("FAIL R2 actual=unexpected window close expected=none");
        end else begin
          it = expQ.pop_front();
          check({it.tag, " word"}, countWord, it.word);
          check("R2 busy length", 32'(runLen), 32'(it.len));
        end
        runLen = 0;
      end
      prevBusy = busy;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    int c1;
    expItem_t it;
    repeat (4) @(negedge clk);
    check("R1 busy in reset", {31'b0, busy}, 32'd0);
    check("R1 counts in reset", countWord, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 counts after reset", countWord, 32'd0);

    // R9: raw level pass-through
    extPre = 4'b1010;
    extClk = 4'b0101;
    #1 check("R9 level word", {24'b0, levelWord}, 32'h0000_00A5);
    extClk = 4'b0011;
    #1 check("R9 level word follows", {24'b0, levelWord}, 32'h0000_00A3);
    extClk = '0;
    extPre = '0;

    // Window A: distinct counts per channel (R4, R5)
    @(negedge clk);
    check("R2 busy before start", {31'b0, busy}, 32'd0);
    fire(c0);
    check("R2 busy after start", {31'b0, busy}, 32'd1);
    it.word = 32'h5A28_1103; it.len = 200; it.tag = "R4 R5";
    expQ.push_back(it);
    repeat (2) @(negedge clk);
    pulses(3, 17, 40, 90);
    waitIdle();
    check("R8 saturation narrow", {16'b0, countN}, 32'h0000_FFF3);

    // R6: edges while idle are ignored
    pulses(9, 9, 9, 9);
    repeat (4) @(negedge clk);
    check("R6 hold wide", countWord, 32'h5A28_1103);
    check("R6 hold narrow", {16'b0, countN}, 32'h0000_FFF3);

    // Window B: fresh counts, not added to previous (R3)
    fire(c0);
    it.word = 32'h0002_0001; it.len = 200; it.tag = "R3";
    expQ.push_back(it);
    repeat (2) @(negedge clk);
    pulses(1, 0, 2, 0);
    waitIdle();

    // Window C: restart in the middle (R7)
    fire(c0);
    repeat (2) @(negedge clk);
    pulses(5, 5, 5, 5);
    repeat (5) @(negedge clk);
    fire(c1);
    check("R7 busy through restart", {31'b0, busy}, 32'd1);
    it.word = 32'h0102_0304; it.len = (c1 - c0) + 200; it.tag = "R7";
    expQ.push_back(it);
    repeat (2) @(negedge clk);
    pulses(4, 3, 2, 1);
    waitIdle();

    // Window D: quiet lines stay at zero (R4)
    fire(c0);
    it.word = 32'h0000_0000; it.len = 200; it.tag = "R4 quiet";
    expQ.push_back(it);
    waitIdle();

    check("R2 queue drained", 32'(expQ.size()), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule